// File: doc/BRIEF.md
# Two-Stage Sigma-Delta Decimator with DC Blocker

This block turns a pair of 1-bit oversampled audio streams, left and right, into 18-bit signed PCM samples. Each input bit arrives at 128 times the output sample rate. The system clock runs at 256 times that rate, so every input bit is held for two clock cycles. One arithmetic datapath serves both channels in turn: left on even cycles and right on odd cycles. The first stage is a fourth-order cascaded integrator-comb filter that decimates by 32. The second stage is an 8-tap symmetric FIR that decimates by 4.

The FIR result is scaled, then clipped to the 18-bit range. A first-order DC blocker can follow it, switched by a level input. Software-free operation is the intent: after reset the block produces a stereo pair every 256 cycles, marked by a one-cycle strobe, with no further control needed.

Top module: `sd_decim`

## Requirements
- R1: A free-running frame counter restarts at 0 when reset is released and counts 256 cycles per output sample. `bitL` is used in cycles where the counter is even, and `bitR` where it is odd. An input bit of 1 counts as +1 and 0 counts as −1, so a stream whose 1-density is above one half gives a positive output (non-inverting).
- R2: Per channel, the first stage is a fourth-order integrator-comb filter. Its comb section runs once every 32 input bits, on the bit with index 31 mod 32 of that channel, and its output magnitude never exceeds 2^20.
- R3: The second stage keeps the last 8 first-stage outputs per channel, newest first. It weights them with −2, 1, 12, 21, 21, 12, 1, −2 and shifts the sum right arithmetically by 9, once per frame.
- R4: The scaled FIR value is clipped to the range −131072 to 131071 before the DC stage. An all-ones stream settles to 131071 and an all-zeros stream settles to −131072.
- R5: With `hpEn` high, out = x − xPrev + yPrev − (yPrev >>> 10), clipped to 18 bits. A constant input gives 0 once the previous input equals the current one.
- R6: With `hpEn` low, the output equals the clipped FIR value. The DC stage then records the input as xPrev and clears yPrev, so enabling it on a steady input produces no step.
- R7: The left sample is updated at the clock edge that ends frame cycle 0, and the right sample at the edge that ends frame cycle 1. `valid` is high for exactly the following cycle, once every 256 cycles.
- R8: A synchronous reset clears all integrator, comb, tap and DC-stage state, and drives `valid` low and both outputs to zero.
- R9: The two channels keep fully separate state. Different densities on left and right give outputs of opposite sign without interaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 256 times the output rate |
| rst | input | 1 | Synchronous active-high reset |
| bitL | input | 1 | Left 1-bit stream, each bit held two cycles |
| bitR | input | 1 | Right 1-bit stream, each bit held two cycles |
| hpEn | input | 1 | Enables the DC-removal stage |
| valid | output | 1 | One-cycle strobe marking a fresh stereo pair |
| dataL | output | 18 | Left sample, two's complement |
| dataR | output | 18 | Right sample, two's complement |

## Verification
The assertions check several properties on every cycle: the strobe is one cycle wide and its spacing is exactly one frame, the bypass path copies the clipped FIR value when the DC stage is off, reset clears the outputs, and the first-stage output stays within its bound. The exact sample values can only be shown by the bench scenarios. These include full-scale streams that drive both clip limits, half-scale densities of each sign on separate channels, an alternating stream that must average to zero, and the DC stage being switched on, stepped and switched off. In each scenario the outputs are compared against a behavioural model.

// File: rtl/sd_decim_pkg.sv
`timescale 1ns/1ps
package sd_decim_pkg;

  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic ch;        // 0 = left slot, 1 = right slot
    logic dump;      // comb section and tap shift for this slot
    logic firGo;     // second stage result taken this slot
    logic pairDone;  // last slot of the stereo pair
  } strobe_t;

  localparam int FIR_TAPS = 8;
  localparam int FIR_COEF [FIR_TAPS] = '{-2, 1, 12, 21, 21, 12, 1, -2};
  localparam int FIR_GAIN_LOG2 = 6;  // coefficients sum to 64

endpackage

// File: rtl/sd_decim_ctrl.sv
`timescale 1ns/1ps
module sd_decim_ctrl
  import sd_decim_pkg::*;
#(
  parameter int CIC_DEC = 32,
  parameter int FIR_DEC = 4
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t stb
);
  localparam int FRAME = 2 * CIC_DEC * FIR_DEC;
  localparam int CNT_W = $clog2(FRAME);
  localparam int DEC_W = $clog2(CIC_DEC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_comb begin
    stb.ch       = cnt[0];
    stb.dump     = &cnt[DEC_W:1];
    stb.firGo    = (cnt[CNT_W-1:1] == '0);
    stb.pairDone = (cnt == CNT_W'(1));
  end

endmodule

// File: rtl/sd_decim_dp.sv
`timescale 1ns/1ps
module sd_decim_dp
  import sd_decim_pkg::*;
#(
  parameter int CIC_ORDER = 4,
  parameter int CIC_DEC   = 32,
  parameter int OUT_W     = 18,
  localparam int CIC_W    = CIC_ORDER * $clog2(CIC_DEC) + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ch,
  input  logic                    dump,
  input  logic                    bitL,
  input  logic                    bitR,
  output logic signed [CIC_W-1:0] cicOut,
  output logic signed [OUT_W-1:0] firSat
);
  localparam int FIR_SHIFT = CIC_ORDER * $clog2(CIC_DEC) + FIR_GAIN_LOG2 - (OUT_W - 1);
  localparam int MAXV = 2 ** (OUT_W - 1) - 1;
  localparam int MINV = -(2 ** (OUT_W - 1));

  logic signed [CIC_W-1:0] integ   [2][CIC_ORDER];
  logic signed [CIC_W-1:0] combDly [2][CIC_ORDER];
  logic signed [CIC_W-1:0] taps    [2][FIR_TAPS];
  logic signed [CIC_W-1:0] sumNext [CIC_ORDER];
  logic signed [CIC_W-1:0] combIn  [CIC_ORDER];
  logic signed [CIC_W-1:0] stage;
  logic signed [31:0]      firAcc;
  logic signed [31:0]      firScaled;
  logic                    bitNow;

  // First stage: integrators every slot, combs on the decimation slot
  always_comb begin
    bitNow = ch ? bitR : bitL;
    stage  = bitNow ? {{(CIC_W-1){1'b0}}, 1'b1} : '1;
    for (int k = 0; k < CIC_ORDER; k++) begin
      sumNext[k] = integ[ch][k] + stage;
      stage      = sumNext[k];
    end
    for (int k = 0; k < CIC_ORDER; k++) begin
      combIn[k] = stage;
      stage     = stage - combDly[ch][k];
    end
    cicOut = stage;
  end

  // Second stage: weighted sum of the tap line, scaled and clipped
  always_comb begin
    firAcc = '0;
    for (int k = 0; k < FIR_TAPS; k++)
      firAcc = firAcc + 32'(taps[ch][k]) * FIR_COEF[k];
    firScaled = firAcc >>> FIR_SHIFT;
    if (firScaled > MAXV)      firSat = OUT_W'(MAXV);
    else if (firScaled < MINV) firSat = OUT_W'(MINV);
    else                       firSat = OUT_W'(firScaled);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < CIC_ORDER; k++) begin
          integ[c][k]   <= '0;
          combDly[c][k] <= '0;
        end
        for (int k = 0; k < FIR_TAPS; k++) taps[c][k] <= '0;
      end
    end else begin
      for (int k = 0; k < CIC_ORDER; k++) integ[ch][k] <= sumNext[k];
      if (dump) begin
        for (int k = 0; k < CIC_ORDER; k++) combDly[ch][k] <= combIn[k];
        taps[ch][0] <= cicOut;
        for (int k = 1; k < FIR_TAPS; k++) taps[ch][k] <= taps[ch][k-1];
      end
    end
  end

endmodule

// File: rtl/sd_decim_hpf.sv
`timescale 1ns/1ps
module sd_decim_hpf #(
  parameter int OUT_W    = 18,
  parameter int HP_SHIFT = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic                    ch,
  input  logic                    done,
  input  logic                    hpEn,
  input  logic signed [OUT_W-1:0] xIn,
  output logic                    valid,
  output logic signed [OUT_W-1:0] dataL,
  output logic signed [OUT_W-1:0] dataR
);
  localparam int W    = OUT_W + 3;
  localparam int MAXV = 2 ** (OUT_W - 1) - 1;
  localparam int MINV = -(2 ** (OUT_W - 1));

  logic signed [OUT_W-1:0] xPrev [2];
  logic signed [OUT_W-1:0] yPrev [2];
  logic signed [W-1:0]     xExt, xpExt, ypExt, sum;
  logic signed [OUT_W-1:0] ySat, yNew;

  always_comb begin
    xExt  = W'(xIn);
    xpExt = W'(xPrev[ch]);
    ypExt = W'(yPrev[ch]);
    sum   = xExt - xpExt + ypExt - (ypExt >>> HP_SHIFT);
    if (int'(sum) > MAXV)      ySat = OUT_W'(MAXV);
    else if (int'(sum) < MINV) ySat = OUT_W'(MINV);
    else                       ySat = OUT_W'(sum);
    yNew = hpEn ? ySat : xIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dataL <= '0;
      dataR <= '0;
      for (int c = 0; c < 2; c++) begin
        xPrev[c] <= '0;
        yPrev[c] <= '0;
      end
    end else begin
      valid <= done;
      if (go) begin
        xPrev[ch] <= xIn;
        yPrev[ch] <= hpEn ? ySat : '0;
        if (ch) dataR <= yNew;
        else    dataL <= yNew;
      end
    end
  end

endmodule

// File: rtl/sd_decim.sv
`timescale 1ns/1ps
module sd_decim
  import sd_decim_pkg::*;
#(
  parameter int CIC_ORDER = 4,
  parameter int CIC_DEC   = 32,
  parameter int FIR_DEC   = 4,
  parameter int OUT_W     = 18,
  parameter int HP_SHIFT  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bitL,
  input  logic                    bitR,
  input  logic                    hpEn,
  output logic                    valid,
  output logic signed [OUT_W-1:0] dataL,
  output logic signed [OUT_W-1:0] dataR
);
  localparam int CIC_W = CIC_ORDER * $clog2(CIC_DEC) + 2;

  strobe_t                 stb;
  logic signed [CIC_W-1:0] cicOut;
  logic signed [OUT_W-1:0] firSat;

  sd_decim_ctrl #(.CIC_DEC(CIC_DEC), .FIR_DEC(FIR_DEC)) u_ctrl (
    .clk(clk), .rst(rst), .stb(stb)
  );

  sd_decim_dp #(.CIC_ORDER(CIC_ORDER), .CIC_DEC(CIC_DEC), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rst(rst), .ch(stb.ch), .dump(stb.dump),
    .bitL(bitL), .bitR(bitR), .cicOut(cicOut), .firSat(firSat)
  );

  sd_decim_hpf #(.OUT_W(OUT_W), .HP_SHIFT(HP_SHIFT)) u_hpf (
    .clk(clk), .rst(rst), .go(stb.firGo), .ch(stb.ch), .done(stb.pairDone),
    .hpEn(hpEn), .xIn(firSat), .valid(valid), .dataL(dataL), .dataR(dataR)
  );

endmodule

// File: rtl/sd_decim_chk.sv
`timescale 1ns/1ps
module sd_decim_chk #(
  parameter int CIC_ORDER = 4,
  parameter int CIC_DEC   = 32,
  parameter int FIR_DEC   = 4,
  parameter int OUT_W     = 18,
  localparam int CIC_W    = CIC_ORDER * $clog2(CIC_DEC) + 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    hpEn,
  input logic                    valid,
  input logic signed [OUT_W-1:0] dataL,
  input logic signed [OUT_W-1:0] dataR,
  input logic                    ch,
  input logic                    dump,
  input logic                    firGo,
  input logic signed [CIC_W-1:0] cicOut,
  input logic signed [OUT_W-1:0] firSat
);
  localparam int FRAME   = 2 * CIC_DEC * FIR_DEC;
  localparam int CIC_LIM = 2 ** (CIC_ORDER * $clog2(CIC_DEC));

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 16'd1;
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7
  valid_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && seen) |-> (gap == 16'(FRAME - 1)));

  // R6
  bypass_left_chk: assert property (@(posedge clk) disable iff (rst)
    (firGo && !ch && !hpEn) |=> (dataL == $past(firSat)));

  // R6
  bypass_right_chk: assert property (@(posedge clk) disable iff (rst)
    (firGo && ch && !hpEn) |=> (dataR == $past(firSat)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid && dataL == '0 && dataR == '0));

  // R2
  cic_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dump |-> (int'(cicOut) <= CIC_LIM && int'(cicOut) >= -CIC_LIM));

endmodule

bind sd_decim sd_decim_chk #(
  .CIC_ORDER(CIC_ORDER), .CIC_DEC(CIC_DEC), .FIR_DEC(FIR_DEC), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .hpEn(hpEn), .valid(valid), .dataL(dataL), .dataR(dataR),
  .ch(stb.ch), .dump(stb.dump), .firGo(stb.firGo), .cicOut(cicOut), .firSat(firSat)
);

// File: tb/sim_sd_decim.sv
`timescale 1ns/1ps
module sim_sd_decim;
  localparam int FRAME   = 256;
  localparam int OUT_MAX = 131071;
  localparam int OUT_MIN = -131072;
  localparam int COEF [8] = '{-2, 1, 12, 21, 21, 12, 1, -2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitL = 1'b0, bitR = 1'b0, hpEn = 1'b0;
  logic valid;
  logic signed [17:0] dataL, dataR;

  always #5 clk = ~clk;

  sd_decim u0 (
    .clk(clk), .rst(rst), .bitL(bitL), .bitR(bitR), .hpEn(hpEn),
    .valid(valid), .dataL(dataL), .dataR(dataR)
  );

  int errors = 0;
  int checks = 0;
  int t = 0;
  bit done = 0;

  // Behavioural reference state
  longint integ [2][4];
  longint dly   [2][4];
  longint taps  [2][8];
  longint xp [2];
  longint yp [2];
  longint expOut [2];
  bit     expValid = 0;
  int     modAcc [2];
  bit     curBit [2];

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp, t);
    end
  endtask

  function automatic longint clip(longint v);
    if (v > OUT_MAX) return OUT_MAX;
    if (v < OUT_MIN) return OUT_MIN;
    return v;
  endfunction

  // first-order density generator: lev in -1000..1000
  function automatic bit modBit(int c, int lev);
    modAcc[c] += lev;
    if (modAcc[c] > 0) begin
      modAcc[c] -= 1000;
      return 1'b1;
    end
    modAcc[c] += 1000;
    return 1'b0;
  endfunction

  // What the coming clock edge does, computed from the requirements
  task automatic modelEdge(int p, bit en);
    int c = p % 2;
    longint s = curBit[c] ? 1 : -1;
    for (int k = 0; k < 4; k++) begin
      integ[c][k] += s;
      s = integ[c][k];
    end
    if (p < 2) begin
      longint acc = 0;
      longint x, y;
      for (int k = 0; k < 8; k++) acc += COEF[k] * taps[c][k];
      x = clip(acc >>> 9);
      if (en) begin
        y = clip(x - xp[c] + yp[c] - (yp[c] >>> 10));
        yp[c] = y;
      end else begin
        y = x;
        yp[c] = 0;
      end
      xp[c] = x;
      expOut[c] = y;
    end
    if (((p >> 1) % 32) == 31) begin
      for (int k = 0; k < 4; k++) begin
        longint d = s - dly[c][k];
        dly[c][k] = s;
        s = d;
      end
      for (int k = 7; k > 0; k--) taps[c][k] = taps[c][k-1];
      taps[c][0] = s;
    end
    expValid = (p == 1);
  endtask

  // Called at a falling edge: compare, drive, model, advance one cycle
  task automatic stepCycle(int levL, int levR, bit en);
    int p = t % FRAME;
    check("R7 valid", longint'(valid), longint'(expValid));
    check("R3 dataL", longint'(dataL), expOut[0]);
    check("R3 dataR", longint'(dataR), expOut[1]);
    if (p % 2 == 0) begin
      curBit[0] = modBit(0, levL);
      curBit[1] = modBit(1, levR);
    end
    bitL = curBit[0];
    bitR = curBit[1];
    hpEn = en;
    modelEdge(p, en);
    t++;
    @(negedge clk);
  endtask

  task automatic runPhase(int frames, int levL, int levR, bit en);
    for (int i = 0; i < frames * FRAME; i++) stepCycle(levL, levR, en);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state at the ports
    check("R8 valid", longint'(valid), 0);
    check("R8 dataL", longint'(dataL), 0);
    check("R8 dataR", longint'(dataR), 0);
    rst = 1'b0;

    // R4: all-ones stream clips high; R1 R2 via reference compare
    runPhase(6, 1000, 1000, 1'b0);
    check("R4 high clip L", longint'(dataL), OUT_MAX);
    check("R4 high clip R", longint'(dataR), OUT_MAX);

    // R4: all-zeros stream clips low
    runPhase(6, -1000, -1000, 1'b0);
    check("R4 low clip L", longint'(dataL), OUT_MIN);

    // R1 non-inverting, R9 channel separation: half scale each sign
    runPhase(6, 500, -500, 1'b0);
    check("R1 positive density L", longint'(dataL), 65536);
    check("R9 negative density R", longint'(dataR), -65536);

    // R2 alternating stream averages exactly to zero
    runPhase(6, 0, 0, 1'b0);
    check("R2 zero mean L", longint'(dataL), 0);
    check("R2 zero mean R", longint'(dataR), 0);

    // R5 DC removal on steady input, R6 no step when enabled
    runPhase(6, 500, 500, 1'b0);
    runPhase(3, 500, 500, 1'b1);
    check("R5 dc removed L", longint'(dataL), 0);
    check("R6 no step R", longint'(dataR), 0);

    // R5 step response while enabled: negative and decaying from the clip
    runPhase(2, -500, -500, 1'b1);
    check("R5 step sign", longint'(dataL < 0), 1);
    check("R5 step decays", longint'(dataL > OUT_MIN), 1);

    // R4 clip ahead of the DC stage, then R6 bypass restores the clip value
    runPhase(4, 1000, 1000, 1'b1);
    runPhase(2, 1000, 1000, 1'b0);
    check("R6 bypass L", longint'(dataL), OUT_MAX);
    runPhase(2, 1000, 1000, 1'b1);
    check("R6 re-enable L", longint'(dataL), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at t=%0d", t);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule